// File: doc/BRIEF.md
# Two-Frame Stub Lookup Sequencer

This block takes one trigger stub per bunch crossing. The stub arrives on a link clock that runs at twice the crossing rate, so each stub is two 16-bit frames, and a phase marker input flags the first frame. The block converts the stub's local chamber coordinates into global values by driving two synchronous lookup memories in series.

The first lookup starts from the first frame alone. It returns a local azimuth and a local bend while the second frame is still on the link. On the next cycle the second-frame fields and the local azimuth form the address for the two global memories. One memory returns a 12-bit global azimuth. The other returns an 11-bit word that holds a 6-bit pseudorapidity and a 5-bit bend. The result is ready one crossing after the first frame enters.

A load port fills all three memories, but only while the block is not running. The memories are kept shallow for simulation: each full lookup address is folded down to the memory's depth by XOR-ing its bits.

Top module: `stub_lut_seq`

## Requirements
- R1: While reset is held and just after it is released, `out_valid`, `out_bx`, `out_phi`, `out_eta`, `out_bend` and `frame_err` are all zero.
- R2: Frame one is the 16-bit local lookup address, laid out as half-strip [15:8], pattern [7:4], quality [3:1] and bend sign [0]. It is folded to LOC_AW bits: bit i of the address is XOR-ed into bit (i mod LOC_AW). The local memory word holds the local azimuth in bits [15:6] and the local bend in bits [5:0].
- R3: Frame two holds valid [15], crossing-number LSBs [14:13], chamber id [12:9], wire group [8:2] and spare [1:0]. The global address is {muon bit = 0, local azimuth [9:1], wire group, chamber id}, which is 21 bits. It is folded to GLB_AW bits by the same rule as R2.
- R4: `out_phi` is the azimuth memory word. `out_eta` is bits [10:5] of the second global word and `out_bend` is bits [4:0]. `out_bx` is the crossing-number field of frame two.
- R5: A stub is complete when a cycle with `frame_first` low follows a cycle with `frame_first` high. Its result appears on the outputs in the cycle after its second frame. The outputs then hold their values until the next stub completes.
- R6: A completed stub whose valid bit is 0 gives `out_valid` = 0 with `out_bx`, `out_phi`, `out_eta` and `out_bend` all zero.
- R7: If `frame_first` is high in two consecutive cycles, the first of those stubs is dropped and the outputs do not change. `frame_err` is set in the next cycle, and the later frame one starts a new stub.
- R8: A cycle with `frame_first` low and no stub pending is ignored, and the outputs do not change.
- R9: A write through the load port (`ld_sel` 0 = local, 1 = global azimuth, 2 = global eta/bend) takes effect only while `run_en` is low. A write made while `run_en` is high leaves the memory unchanged.
- R10: Once `frame_err` is set, it stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock, two cycles per crossing |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | High while processing; blocks memory loads |
| frame_first | input | 1 | Marks frame one of a stub |
| frame_in | input | 16 | Link frame data |
| ld_en | input | 1 | Memory write strobe |
| ld_sel | input | 2 | Memory select for the write |
| ld_addr | input | LD_AW | Write address |
| ld_data | input | 16 | Write data (low bits used by narrower memories) |
| out_valid | output | 1 | Stub valid for the current result |
| out_bx | output | 2 | Crossing-number LSBs |
| out_phi | output | 12 | Global azimuth |
| out_eta | output | 6 | Global pseudorapidity |
| out_bend | output | 5 | Global bend |
| frame_err | output | 1 | Sticky framing error |

## Verification
The assertions assume that `frame_first` is a clean level sampled once per link cycle. They also assume that nothing reads a memory in the same cycle that the load port writes the same memory. The stimulus keeps to both assumptions: all loads happen during idle link cycles, and the frame marker is driven only on the falling edge. Framing faults are injected on purpose, as a repeated frame-one marker and as stray second frames, so that the hold and sticky-error properties are exercised instead of being met trivially.

// File: rtl/stub_lut_pkg.sv
package stub_lut_pkg;
  localparam int FRAME_W = 16;
  localparam int LPHI_W  = 10;
  localparam int LBEND_W = 6;
  localparam int GPHI_W  = 12;
  localparam int ETA_W   = 6;
  localparam int GBEND_W = 5;
  localparam int EB_W    = ETA_W + GBEND_W;
  localparam int WG_W    = 7;
  localparam int CSC_W   = 4;
  localparam int BX_W    = 2;

  typedef struct packed {
    logic             valid;
    logic [BX_W-1:0]  bx;
    logic [CSC_W-1:0] csc;
    logic [WG_W-1:0]  wg;
    logic [1:0]       spare;
  } frame2_t;

  typedef struct packed {
    logic [LPHI_W-1:0]  lphi;
    logic [LBEND_W-1:0] lbend;
  } local_word_t;

  // XOR-fold a wide lookup address onto a shallow memory
  function automatic logic [31:0] fold_addr(input logic [31:0] a, input int aw);
    logic [31:0] r;
    r = '0;
    for (int i = 0; i < 32; i++) r[i % aw] = r[i % aw] ^ a[i];
    return r;
  endfunction

  // stage-two address: muon bit, upper local azimuth, wire group, chamber
  function automatic logic [31:0] stage2_addr(input logic muon,
                                              input logic [LPHI_W-2:0] lphi_hi,
                                              input logic [WG_W-1:0] wg,
                                              input logic [CSC_W-1:0] csc);
    return {11'b0, muon, lphi_hi, wg, csc};
  endfunction
endpackage

// File: rtl/stub_sync_lut.sv
module stub_sync_lut #(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/stub_frame_tracker.sv
module stub_frame_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_first,
  output logic pend_o,
  output logic done_o,
  output logic dup_o,
  output logic err_o
);
  logic pend_q;
  logic err_q;

  assign pend_o = pend_q;
  assign done_o = pend_q && !frame_first;
  assign dup_o  = pend_q && frame_first;
  assign err_o  = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      pend_q <= frame_first;
      if (dup_o) err_q <= 1'b1;
    end
  end
endmodule

// File: rtl/stub_lut_seq.sv
module stub_lut_seq
  import stub_lut_pkg::*;
#(
  parameter int LOC_AW = 6,
  parameter int GLB_AW = 8,
  parameter int LD_AW  = (LOC_AW > GLB_AW) ? LOC_AW : GLB_AW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run_en,
  input  logic                 frame_first,
  input  logic [FRAME_W-1:0]   frame_in,
  input  logic                 ld_en,
  input  logic [1:0]           ld_sel,
  input  logic [LD_AW-1:0]     ld_addr,
  input  logic [15:0]          ld_data,
  output logic                 out_valid,
  output logic [BX_W-1:0]      out_bx,
  output logic [GPHI_W-1:0]    out_phi,
  output logic [ETA_W-1:0]     out_eta,
  output logic [GBEND_W-1:0]   out_bend,
  output logic                 frame_err
);
  localparam logic MUON_BIT = 1'b0;
  localparam int   NMEM     = 3;

  logic pend_q, stub_done, dup_evt;
  logic [NMEM-1:0] mem_we;

  stub_frame_tracker u_trk (
    .clk(clk), .rst_n(rst_n), .frame_first(frame_first),
    .pend_o(pend_q), .done_o(stub_done), .dup_o(dup_evt), .err_o(frame_err)
  );

  // write strobes, one per memory, gated off while running
  for (genvar g = 0; g < NMEM; g++) begin : g_we
    assign mem_we[g] = ld_en && !run_en && (ld_sel == 2'(g));
  end

  // stage one: local lookup from frame one
  logic [LOC_AW-1:0] loc_raddr;
  logic [15:0]       loc_rdata;
  local_word_t       lw;

  assign loc_raddr = LOC_AW'(fold_addr(32'(frame_in), LOC_AW));
  assign lw        = local_word_t'(loc_rdata);

  stub_sync_lut #(.AW(LOC_AW), .DW(16)) u_loc (
    .clk(clk), .rst_n(rst_n), .we(mem_we[0]),
    .waddr(ld_addr[LOC_AW-1:0]), .wdata(ld_data),
    .re(frame_first), .raddr(loc_raddr), .rdata(loc_rdata)
  );

  // stage two: global lookups from local result and frame two
  frame2_t           f2;
  logic [31:0]       g_full;
  logic [GLB_AW-1:0] g_raddr;
  logic [GPHI_W-1:0] phi_rd;
  logic [EB_W-1:0]   eb_rd;

  assign f2      = frame2_t'(frame_in);
  assign g_full  = stage2_addr(MUON_BIT, lw.lphi[LPHI_W-1:1], f2.wg, f2.csc);
  assign g_raddr = GLB_AW'(fold_addr(g_full, GLB_AW));

  stub_sync_lut #(.AW(GLB_AW), .DW(GPHI_W)) u_gphi (
    .clk(clk), .rst_n(rst_n), .we(mem_we[1]),
    .waddr(ld_addr[GLB_AW-1:0]), .wdata(ld_data[GPHI_W-1:0]),
    .re(stub_done), .raddr(g_raddr), .rdata(phi_rd)
  );

  stub_sync_lut #(.AW(GLB_AW), .DW(EB_W)) u_geb (
    .clk(clk), .rst_n(rst_n), .we(mem_we[2]),
    .waddr(ld_addr[GLB_AW-1:0]), .wdata(ld_data[EB_W-1:0]),
    .re(stub_done), .raddr(g_raddr), .rdata(eb_rd)
  );

  // per-crossing tag registers, aligned with global read data
  logic            v_q;
  logic [BX_W-1:0] bx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q  <= 1'b0;
      bx_q <= '0;
    end else if (stub_done) begin
      v_q  <= f2.valid;
      bx_q <= f2.bx;
    end
  end

  assign out_valid = v_q;
  assign out_bx    = v_q ? bx_q : '0;
  assign out_phi   = v_q ? phi_rd : '0;
  assign out_eta   = v_q ? eb_rd[EB_W-1:GBEND_W] : '0;
  assign out_bend  = v_q ? eb_rd[GBEND_W-1:0] : '0;

  logic fields_unused;
  assign fields_unused = ^{lw.lbend, lw.lphi[0], f2.spare};
endmodule

// File: rtl/stub_lut_seq_chk.sv
module stub_lut_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        frame_first,
  input logic [15:0] frame_in,
  input logic        pend_q,
  input logic        stub_done,
  input logic        dup_evt,
  input logic        out_valid,
  input logic [1:0]  out_bx,
  input logic [11:0] out_phi,
  input logic [5:0]  out_eta,
  input logic [4:0]  out_bend,
  input logic        frame_err
);
  // R6
  invalid_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (out_phi == 12'd0 && out_eta == 6'd0 && out_bend == 5'd0 && out_bx == 2'd0));

  // R5
  hold_between_stubs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stub_done |=> ($stable(out_valid) && $stable(out_phi) && $stable(out_eta)
                    && $stable(out_bend) && $stable(out_bx)));

  // R3
  valid_follows_frame2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stub_done |=> (out_valid == $past(frame_in[15])));

  // R7
  dup_sets_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_first && pend_q) |=> frame_err);

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> frame_err);

  // R8
  idle_no_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_first && !pend_q) |=> !pend_q);

  // R7
  dup_not_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dup_evt |-> !stub_done);
endmodule

bind stub_lut_seq stub_lut_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .frame_first(frame_first), .frame_in(frame_in),
  .pend_q(pend_q), .stub_done(stub_done), .dup_evt(dup_evt),
  .out_valid(out_valid), .out_bx(out_bx), .out_phi(out_phi),
  .out_eta(out_eta), .out_bend(out_bend), .frame_err(frame_err)
);

// File: tb/stub_lut_seq_tb_top.sv
module stub_lut_seq_tb_top;
  localparam int LOC_AW = 6;
  localparam int GLB_AW = 8;
  localparam int LD_AW  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run_en = 1'b0;
  logic frame_first = 1'b0;
  logic [15:0] frame_in = '0;
  logic ld_en = 1'b0;
  logic [1:0] ld_sel = '0;
  logic [LD_AW-1:0] ld_addr = '0;
  logic [15:0] ld_data = '0;
  logic out_valid, frame_err;
  logic [1:0] out_bx;
  logic [11:0] out_phi;
  logic [5:0] out_eta;
  logic [4:0] out_bend;

  always #5 clk = ~clk;

  stub_lut_seq #(.LOC_AW(LOC_AW), .GLB_AW(GLB_AW), .LD_AW(LD_AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .frame_first(frame_first),
    .frame_in(frame_in), .ld_en(ld_en), .ld_sel(ld_sel), .ld_addr(ld_addr),
    .ld_data(ld_data), .out_valid(out_valid), .out_bx(out_bx), .out_phi(out_phi),
    .out_eta(out_eta), .out_bend(out_bend), .frame_err(frame_err)
  );

  int checks = 0;
  int fails = 0;
  int unsigned seed = 32'h1234_5678;

  // reference model state
  int m_loc [64];
  int m_phi [256];
  int m_eb  [256];
  int m_lq = 0;
  int m_v = 0, m_bx = 0, m_phi_q = 0, m_eb_q = 0;
  int m_pend = 0, m_err = 0;

  function automatic int unsigned rnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  // restated fold: XOR of aw-bit chunks
  function automatic int bfold(int unsigned a, int aw);
    int r = 0;
    for (int j = 0; j < 32; j += aw) r = r ^ int'((a >> j) & ((32'd1 << aw) - 1));
    return r;
  endfunction

  function automatic int g_addr(int lq, int f2);
    int unsigned full;
    full = ((((lq >> 6) & 10'h3FF) >> 1) << 11) | (((f2 >> 2) & 8'h7F) << 4) | ((f2 >> 9) & 4'hF);
    return bfold(full, GLB_AW);
  endfunction

  task automatic cmp(string req);
    int e_phi, e_eta, e_bend, e_bx;
    e_phi  = m_v ? m_phi_q : 0;
    e_eta  = m_v ? (m_eb_q >> 5) & 6'h3F : 0;
    e_bend = m_v ? m_eb_q & 5'h1F : 0;
    e_bx   = m_v ? m_bx : 0;
    checks++;
    if (out_valid !== 1'(m_v) || out_phi !== 12'(e_phi) || out_eta !== 6'(e_eta) ||
        out_bend !== 5'(e_bend) || out_bx !== 2'(e_bx) || frame_err !== 1'(m_err)) begin
      fails++;
      $display("FAIL %s: actual v=%0d bx=%0d phi=%0d eta=%0d bend=%0d err=%0d expected v=%0d bx=%0d phi=%0d eta=%0d bend=%0d err=%0d",
               req, out_valid, out_bx, out_phi, out_eta, out_bend, frame_err,
               m_v, e_bx, e_phi, e_eta, e_bend, m_err);
    end
  endtask

  // one link cycle: drive at falling edge, model at rising edge, compare at next falling edge
  task automatic step(bit ff, logic [15:0] fr, bit le, int sel, int addr, int data, string req);
    int lq_new;
    frame_first = ff; frame_in = fr; ld_en = le;
    ld_sel = 2'(sel); ld_addr = LD_AW'(addr); ld_data = 16'(data);
    @(posedge clk);
    if (!rst_n) begin
      m_lq = 0; m_v = 0; m_bx = 0; m_phi_q = 0; m_eb_q = 0; m_pend = 0; m_err = 0;
    end else begin
      lq_new = m_lq;
      if (ff) lq_new = m_loc[bfold(fr, LOC_AW)];
      if (m_pend && !ff) begin
        m_phi_q = m_phi[g_addr(m_lq, fr)];
        m_eb_q  = m_eb[g_addr(m_lq, fr)];
        m_v     = fr[15];
        m_bx    = (fr >> 13) & 2'h3;
      end
      if (m_pend && ff) m_err = 1;
      m_pend = ff;
      m_lq = lq_new;
      if (le && !run_en) begin
        if (sel == 0) m_loc[addr % 64] = data & 16'hFFFF;
        if (sel == 1) m_phi[addr] = data & 12'hFFF;
        if (sel == 2) m_eb[addr]  = data & 11'h7FF;
      end
    end
    @(negedge clk);
    cmp(req);
  endtask

  task automatic idle(string req);
    step(0, 16'(rnd()), 0, 0, 0, 0, req);
  endtask

  task automatic stub(logic [15:0] f1, logic [15:0] f2, string req);
    step(1, f1, 0, 0, 0, 0, req);
    step(0, f2, 0, 0, 0, 0, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R5 watchdog: actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] f1, f2;
    int a;
    @(negedge clk);
    repeat (3) step(0, 16'h0, 0, 0, 0, 0, "R1");
    rst_n = 1'b1;
    idle("R1");

    // R9: load all memories while stopped
    for (int i = 0; i < 64; i++)  step(0, 16'h0, 1, 0, i, (i * 40503 + 17) ^ (i << 9), "R9");
    for (int i = 0; i < 256; i++) step(0, 16'h0, 1, 1, i, i * 91 + 3, "R9");
    for (int i = 0; i < 256; i++) step(0, 16'h0, 1, 2, i, i * 53 + 7, "R9");
    run_en = 1'b1;
    idle("R8");

    // R2 R3 R4: back-to-back valid stubs
    for (int i = 0; i < 40; i++) stub(16'(rnd()), 16'(rnd()) | 16'h8000, "R2_R3_R4");
    // R5 R8: hold through stray second frames
    repeat (6) idle("R5_R8");
    // R6: invalid stubs
    for (int i = 0; i < 8; i++) stub(16'(rnd()), 16'(rnd()) & 16'h7FFF, "R6");
    stub(16'(rnd()), 16'(rnd()) | 16'h8000, "R5");
    repeat (3) idle("R5");
    // R7: repeated frame one
    step(1, 16'(rnd()), 0, 0, 0, 0, "R7");
    step(1, 16'(rnd()), 0, 0, 0, 0, "R7");
    step(0, 16'(rnd()) | 16'h8000, 0, 0, 0, 0, "R7");
    // R10: error stays set
    for (int i = 0; i < 10; i++) stub(16'(rnd()), 16'(rnd()), "R10");

    // R9: load during run is ignored, then takes effect when stopped
    f1 = 16'(rnd()); f2 = 16'(rnd()) | 16'h8000;
    a = g_addr(m_loc[bfold(f1, LOC_AW)], f2);
    step(0, 16'h0, 1, 1, a, 12'hABC, "R9");
    step(0, 16'h0, 1, 2, a, 11'h555, "R9");
    stub(f1, f2, "R9");
    run_en = 1'b0;
    step(0, 16'h0, 1, 1, a, 12'h123, "R9");
    step(0, 16'h0, 1, 2, a, 11'h2AA, "R9");
    run_en = 1'b1;
    stub(f1, f2, "R9");
    repeat (2) idle("R9");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule